// File: doc/BRIEF.md
# Eight-Port Fan PWM Generator with Shared Timebases

This block drives eight fan PWM outputs from three shared timebases, called M, N and O. Each timebase has a prescaler and a period counter. The prescaler divides the selected source tick by a low factor times a power-of-two high factor. The period counter then counts unit+1 prescaled ticks per period. Each output port picks one timebase and compares that timebase's counter against its own rise and fall points. Several fans can therefore share a frequency while keeping their own duty.

Software configures the block through a single-cycle register write port. One register holds a global run bit and a source select. The source select chooses between a fixed reference tick and an alternate tick; both are one-cycle enables in the `clk` domain. Other registers hold the port enables, the per-port timebase selectors, the timebase dividers (M and N share one word, O has its own) and one duty word per port.

Top module: `fanpwm_bank`

## Requirements
- R1: During and after reset all outputs are low and every register reads as zero, so the run bit starts cleared.
- R2: Address 0 bit 0 is the run bit. While it is 0 all prescalers and period counters stay at zero, and every output is low from the next clock onward.
- R3: Address 0 bit 1 selects the count source: 0 uses `ref_tick`, 1 uses `alt_tick`. The counters advance only on cycles where the selected tick is high.
- R4: Low factor: 1 when the low field is 0, otherwise twice the field. High factor: 2 to the power of the high field. A period lasts low factor × high factor × (unit+1) source ticks. The period counter steps by one or wraps to zero.
- R5: Address 3 holds M in bits [15:0] and N in bits [31:16]. Address 4 holds O in bits [15:0]. Each 16-bit group has the low field at [3:0], the high field at [7:4] and the unit at [15:8].
- R6: Address 1 bit p enables port p. A disabled port drives its output low from the next clock onward.
- R7: Address 2 bits [2p+1:2p] choose the timebase for port p: 0 for M, 1 for N, 2 for O. Code 3 selects none and holds the output low.
- R8: Address 8+p holds the duty of port p: rise point in [7:0], fall point in [15:8]. The output is high while counter ≥ rise and (fall = 0 or counter < fall). With rise < fall it stays high for (fall − rise) prescaled ticks per period.
- R9: With rise 0 and fall 0 an enabled port on a valid timebase is high for the whole period.
- R10: A new duty word takes effect only at the next period boundary of the selected timebase, so the period in progress keeps its old shape.
- R11: Writing a timebase's divider word restarts that timebase's prescaler and counter at zero. The same write loads its ports' pending duty, and the new period starts on the following clock.
- R12: A period counter never exceeds its unit field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Fixed-reference count enable |
| alt_tick | input | 1 | Alternate-source count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 32 | Register write data |
| pwm_out | output | 8 | PWM outputs, one per port |

## Verification
A wrong prescaler terminal count or a wrong counter wrap point changes the period measured between rising edges, and it shows within the first period after configuration. Measuring both the period and the high time across a sweep of divider fields and fall points pins down the exact divider arithmetic. A duty that is loaded early, or a restart that is missed, distorts the period in progress, which the bench checks within a few cycles of the write. Errors in the gating of enables and selectors show up one clock later as a stray high level on an output that must be idle.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
    localparam int PORTS  = 8;
    localparam int TYPES  = 3;
    localparam int LOW_W  = 4;
    localparam int HIGH_W = 4;
    localparam int UNIT_W = 8;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;
    localparam int TSEL_W = 2;
    localparam int CFG_W  = LOW_W + HIGH_W + UNIT_W;
    localparam int PRE_W  = LOW_W + (1 << HIGH_W);

    localparam int A_GLOBAL = 0;
    localparam int A_PEN    = 1;
    localparam int A_TSEL   = 2;
    localparam int A_MN     = 3;
    localparam int A_O      = 4;
    localparam int A_DUTY0  = 8;

    localparam logic [TSEL_W-1:0] SEL_NONE = 2'd3;

    typedef struct packed {
        logic [UNIT_W-1:0] unit;
        logic [HIGH_W-1:0] hi;
        logic [LOW_W-1:0]  lo;
    } tcfg_t;

    typedef struct packed {
        logic [UNIT_W-1:0] fall;
        logic [UNIT_W-1:0] rise;
    } duty_t;

    function automatic logic [PRE_W-1:0] pre_terminal(tcfg_t c);
        logic [PRE_W-1:0] lf;
        lf = (c.lo == '0) ? PRE_W'(1) : PRE_W'({c.lo, 1'b0});
        return (lf << c.hi) - PRE_W'(1);
    endfunction
endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int NPORT = PORTS,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    output logic                         glob_en,
    output logic                         src_alt,
    output logic [NPORT-1:0]             port_en,
    output logic [NPORT-1:0][TSEL_W-1:0] tsel_vec,
    output tcfg_t [TYPES-1:0]            tcfg,
    output duty_t [NPORT-1:0]            duty_pend,
    output logic [TYPES-1:0]             restart
);
    logic hit_mn, hit_o;
    assign hit_mn = wr_en && (wr_addr == AW'(A_MN));
    assign hit_o  = wr_en && (wr_addr == AW'(A_O));

    assign restart[0] = hit_mn;
    assign restart[1] = hit_mn;
    assign restart[2] = hit_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            glob_en   <= 1'b0;
            src_alt   <= 1'b0;
            port_en   <= '0;
            tsel_vec  <= '0;
            tcfg      <= '0;
            duty_pend <= '0;
        end else if (wr_en) begin
            if (wr_addr == AW'(A_GLOBAL)) begin
                glob_en <= wr_data[0];
                src_alt <= wr_data[1];
            end
            if (wr_addr == AW'(A_PEN)) begin
                port_en <= wr_data[NPORT-1:0];
            end
            if (wr_addr == AW'(A_TSEL)) begin
                for (int p = 0; p < NPORT; p++) begin
                    tsel_vec[p] <= wr_data[p*TSEL_W +: TSEL_W];
                end
            end
            if (hit_mn) begin
                tcfg[0] <= tcfg_t'(wr_data[0 +: CFG_W]);
                tcfg[1] <= tcfg_t'(wr_data[CFG_W +: CFG_W]);
            end
            if (hit_o) begin
                tcfg[2] <= tcfg_t'(wr_data[0 +: CFG_W]);
            end
            for (int p = 0; p < NPORT; p++) begin
                if (wr_addr == AW'(A_DUTY0 + p)) begin
                    duty_pend[p] <= duty_t'(wr_data[0 +: 2*UNIT_W]);
                end
            end
        end
    end
endmodule

// File: rtl/fanpwm_timebase.sv
module fanpwm_timebase
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              tick,
    input  logic              restart,
    input  tcfg_t             cfg,
    output logic [UNIT_W-1:0] cnt,
    output logic              bound
);
    logic [PRE_W-1:0]  pre_q;
    logic [PRE_W-1:0]  term;
    logic [UNIT_W-1:0] cnt_q;
    logic              ptick;
    logic              last;

    assign term  = pre_terminal(cfg);
    assign ptick = tick && (pre_q >= term);
    assign last  = (cnt_q >= cfg.unit);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) begin
            pre_q <= '0;
            cnt_q <= '0;
        end else if (tick) begin
            if (pre_q >= term) begin
                pre_q <= '0;
                cnt_q <= last ? '0 : cnt_q + UNIT_W'(1);
            end else begin
                pre_q <= pre_q + PRE_W'(1);
            end
        end
    end

    assign cnt   = cnt_q;
    assign bound = !run || restart || (ptick && last);
endmodule

// File: rtl/fanpwm_port.sv
module fanpwm_port
    import fanpwm_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         run,
    input  logic                         en,
    input  logic [TSEL_W-1:0]            tsel,
    input  logic [TYPES-1:0][UNIT_W-1:0] cnt_all,
    input  logic [TYPES-1:0]             bound_all,
    input  duty_t                        pend,
    output duty_t                        act,
    output logic                         load,
    output logic                         pwm
);
    logic              valid;
    logic [UNIT_W-1:0] cnt_sel;
    logic              hi;
    duty_t             act_q;
    logic              pwm_q;

    always_comb begin
        valid   = 1'b0;
        cnt_sel = '0;
        load    = 1'b1;
        for (int t = 0; t < TYPES; t++) begin
            if (tsel == TSEL_W'(t)) begin
                valid   = 1'b1;
                cnt_sel = cnt_all[t];
                load    = bound_all[t];
            end
        end
    end

    assign hi = (cnt_sel >= act_q.rise) &&
                ((act_q.fall == '0) || (cnt_sel < act_q.fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            pwm_q <= 1'b0;
        end else begin
            if (load) begin
                act_q <= pend;
            end
            pwm_q <= run && en && valid && hi;
        end
    end

    assign act = act_q;
    assign pwm = pwm_q;
endmodule

// File: rtl/fanpwm_bank.sv
module fanpwm_bank
    import fanpwm_pkg::*;
#(
    parameter int NPORT = PORTS,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_tick,
    input  logic             alt_tick,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [NPORT-1:0] pwm_out
);
    logic                         glob_en;
    logic                         src_alt;
    logic [NPORT-1:0]             port_en;
    logic [NPORT-1:0][TSEL_W-1:0] tsel_vec;
    tcfg_t [TYPES-1:0]            tcfg;
    duty_t [NPORT-1:0]            duty_pend;
    logic [TYPES-1:0]             restart;
    logic [TYPES-1:0][UNIT_W-1:0] tb_cnt;
    logic [TYPES-1:0]             tb_bound;
    duty_t [NPORT-1:0]            act;
    logic [NPORT-1:0]             ld;
    logic                         src_tick;

    fanpwm_regs #(.NPORT(NPORT), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .glob_en   (glob_en),
        .src_alt   (src_alt),
        .port_en   (port_en),
        .tsel_vec  (tsel_vec),
        .tcfg      (tcfg),
        .duty_pend (duty_pend),
        .restart   (restart)
    );

    assign src_tick = src_alt ? alt_tick : ref_tick;

    for (genvar t = 0; t < TYPES; t++) begin : g_tb
        fanpwm_timebase u_tb (
            .clk     (clk),
            .rst     (rst),
            .run     (glob_en),
            .tick    (src_tick),
            .restart (restart[t]),
            .cfg     (tcfg[t]),
            .cnt     (tb_cnt[t]),
            .bound   (tb_bound[t])
        );
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        fanpwm_port u_port (
            .clk       (clk),
            .rst       (rst),
            .run       (glob_en),
            .en        (port_en[p]),
            .tsel      (tsel_vec[p]),
            .cnt_all   (tb_cnt),
            .bound_all (tb_bound),
            .pend      (duty_pend[p]),
            .act       (act[p]),
            .load      (ld[p]),
            .pwm       (pwm_out[p])
        );
    end
endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk
    import fanpwm_pkg::*;
#(
    parameter int NPORT = PORTS
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         glob_en,
    input logic [NPORT-1:0]             port_en,
    input logic [NPORT-1:0][TSEL_W-1:0] tsel_vec,
    input tcfg_t [TYPES-1:0]            tcfg,
    input logic [TYPES-1:0]             restart,
    input logic [TYPES-1:0][UNIT_W-1:0] tb_cnt,
    input duty_t [NPORT-1:0]            act,
    input logic [NPORT-1:0]             ld,
    input logic [NPORT-1:0]             pwm_out
);
    assert_gate_off_R2: assert property (@(posedge clk) disable iff (rst)
        !glob_en |=> (pwm_out == '0));

    for (genvar t = 0; t < TYPES; t++) begin : g_t
        assert_cnt_range_R12: assert property (@(posedge clk) disable iff (rst)
            tb_cnt[t] <= tcfg[t].unit);
        assert_cnt_step_R4: assert property (@(posedge clk) disable iff (rst)
            (tb_cnt[t] != $past(tb_cnt[t])) |->
            ((tb_cnt[t] == '0) || (tb_cnt[t] == $past(tb_cnt[t]) + UNIT_W'(1))));
        assert_restart_R11: assert property (@(posedge clk) disable iff (rst)
            restart[t] |=> (tb_cnt[t] == '0));
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_p
        assert_port_off_R6: assert property (@(posedge clk) disable iff (rst)
            !port_en[p] |=> !pwm_out[p]);
        assert_no_type_R7: assert property (@(posedge clk) disable iff (rst)
            (tsel_vec[p] == SEL_NONE) |=> !pwm_out[p]);
        assert_full_on_R9: assert property (@(posedge clk) disable iff (rst)
            (glob_en && port_en[p] && (tsel_vec[p] != SEL_NONE) && (act[p] == '0))
            |=> pwm_out[p]);
        assert_duty_hold_R10: assert property (@(posedge clk) disable iff (rst)
            !ld[p] |=> $stable(act[p]));
    end
endmodule

bind fanpwm_bank fanpwm_chk #(.NPORT(NPORT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .glob_en  (glob_en),
    .port_en  (port_en),
    .tsel_vec (tsel_vec),
    .tcfg     (tcfg),
    .restart  (restart),
    .tb_cnt   (tb_cnt),
    .act      (act),
    .ld       (ld),
    .pwm_out  (pwm_out)
);

// File: tb/sim_fanpwm_bank.sv
module sim_fanpwm_bank;
    import fanpwm_pkg::*;

    localparam int LIM = 20000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ref_tick = 1'b1;
    logic              alt_tick = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [PORTS-1:0]  pwm_out;

    int vectors = 0;
    int miscompares = 0;
    int alt_cnt = 0;
    bit done = 0;

    fanpwm_bank u0 (
        .clk(clk), .rst(rst), .ref_tick(ref_tick), .alt_tick(alt_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .pwm_out(pwm_out)
    );

    always #4 clk = ~clk;

    // alternate source: one tick every third cycle
    always @(negedge clk) begin
        alt_cnt  = (alt_cnt == 2) ? 0 : alt_cnt + 1;
        alt_tick = (alt_cnt == 0);
    end

    task automatic chk(string req, int actual, int expected);
        vectors++;
        if (actual != expected) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] cfg(int lo, int hi, int unit);
        return {8'(unit), 4'(hi), 4'(lo)};
    endfunction

    function automatic int lfac(int lo);
        return (lo == 0) ? 1 : 2 * lo;
    endfunction

    // cycles between two rising edges and high samples within that span
    task automatic measure(int p, output int per, output int hi);
        int g;
        logic last;
        g = 0; per = 0; hi = 0;
        @(negedge clk);
        while (pwm_out[p] !== 1'b0 && g < LIM) begin @(negedge clk); g++; end
        while (pwm_out[p] !== 1'b1 && g < LIM) begin @(negedge clk); g++; end
        last = 1'b1;
        while (g < LIM) begin
            if (pwm_out[p]) hi++;
            per++;
            last = pwm_out[p];
            @(negedge clk); g++;
            if (pwm_out[p] && !last) break;
        end
        if (g >= LIM) begin per = -1; hi = -1; end
    endtask

    task automatic count_high(int p, int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[p]) hi++;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int per, hi, n;
        logic [31:0] tsel_word;
        repeat (4) @(negedge clk);
        chk("R1 outputs in reset", int'(pwm_out), 0);
        rst = 1'b0;
        count_high(0, 20, hi);
        chk("R1 idle after reset", hi, 0);

        // port types: 0,1,5,6 -> M ; 2,3 -> N ; 4 -> none ; 7 -> O
        tsel_word = '0;
        tsel_word[5:4]   = 2'd1;
        tsel_word[7:6]   = 2'd1;
        tsel_word[9:8]   = 2'd3;
        tsel_word[15:14] = 2'd2;
        wr(A_TSEL, tsel_word);
        wr(A_PEN, 32'hFF);
        wr(A_GLOBAL, 32'h1);
        wr(A_DUTY0 + 3, {16'h0, 8'd2, 8'd0});
        wr(A_DUTY0 + 7, {16'h0, 8'd3, 8'd1});
        wr(A_O, {16'h0, cfg(1, 1, 4)});

        // R4/R8 sweep on port 0 with M; N kept at lo=3 hi=0 unit=2
        for (int lo = 0; lo < 3; lo++) begin
            for (int h = 0; h < 3; h++) begin
                for (int f = 1; f < 4; f++) begin
                    wr(A_DUTY0 + 0, {16'h0, 8'(f), 8'd0});
                    wr(A_MN, {cfg(3, 0, 2), cfg(lo, h, 3)});
                    measure(0, per, hi);
                    n = lfac(lo) * (1 << h);
                    chk("R4 period", per, n * 4);
                    chk("R8 high time", hi, n * f);
                end
            end
        end

        // R8 nonzero rise point
        wr(A_DUTY0 + 0, {16'h0, 8'd3, 8'd1});
        wr(A_MN, {cfg(3, 0, 2), cfg(1, 1, 5)});
        measure(0, per, hi);
        chk("R4 period rise test", per, 4 * 6);
        chk("R8 rise1 fall3", hi, 4 * 2);

        // R9 port 5: default duty word is zero -> always high
        count_high(5, 60, hi);
        chk("R9 full duty", hi, 60);

        // R5 types N and O
        measure(3, per, hi);
        chk("R5 N period", per, 6 * 3);
        chk("R5 N high", hi, 6 * 2);
        measure(7, per, hi);
        chk("R5 O period", per, 4 * 5);
        chk("R5 O high", hi, 4 * 2);

        // R3 alternate source
        wr(A_GLOBAL, 32'h3);
        measure(0, per, hi);
        measure(0, per, hi);
        chk("R3 alt period", per, 3 * 4 * 6);
        chk("R3 alt high", hi, 3 * 4 * 2);
        wr(A_GLOBAL, 32'h1);

        // R7 selector code 3
        count_high(4, 60, hi);
        chk("R7 no type low", hi, 0);

        // R6 disable port 3
        wr(A_PEN, 32'hF7);
        count_high(3, 60, hi);
        chk("R6 disabled low", hi, 0);
        wr(A_PEN, 32'hFF);
        measure(3, per, hi);
        chk("R6 re-enabled high", hi, 6 * 2);

        // R10 deferred duty update on port 1 (M, factor 1, 256-cycle period)
        wr(A_DUTY0 + 1, {16'h0, 8'd10, 8'd0});
        wr(A_MN, {cfg(3, 0, 2), cfg(0, 0, 255)});
        n = 0;
        while (pwm_out[1] !== 1'b1 && n < LIM) begin @(negedge clk); n++; end
        while (pwm_out[1] !== 1'b0 && n < LIM) begin @(negedge clk); n++; end
        wr(A_DUTY0 + 1, {16'h0, 8'd200, 8'd0});
        count_high(1, 100, hi);
        chk("R10 old period kept", hi, 0);
        measure(1, per, hi);
        chk("R10 new high time", hi, 200);
        chk("R10 period", per, 256);

        // R11 restart on divider write (port 2 on N, factor 1, unit 255)
        wr(A_DUTY0 + 2, {16'h0, 8'd5, 8'd0});
        wr(A_MN, {cfg(0, 0, 255), cfg(0, 0, 255)});
        count_high(2, 30, hi);
        chk("R11 low mid period", int'(pwm_out[2]), 0);
        wr(A_MN, {cfg(0, 0, 255), cfg(0, 0, 255)});
        @(negedge clk);
        chk("R11 restart high", int'(pwm_out[2]), 1);
        count_high(2, 10, hi);
        chk("R11 restart high time", hi, 4);

        // R2 global disable
        wr(A_GLOBAL, 32'h0);
        @(negedge clk);
        n = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            if (pwm_out != '0) n++;
        end
        chk("R2 all low when stopped", n, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule